// File: doc/BRIEF.md
# Two-Wire Write-Only Converter Register Slave

This block is the serial front end of an 8-bit converter register with a power-down control. It watches a two-wire bus (clock and data lines) through synchronisers running on the system clock. It recognises its own 7-bit address, which is formed from a fixed upper part and a 2-bit select input. The bit that follows the address is taken as a shutdown request. The block then receives one data byte. It only ever pulls the data line low, and only to acknowledge a byte.

New values reach the outputs only when a STOP follows a complete second byte. In normal mode (shutdown bit 0) the master writes the code and the block acknowledges it. In shutdown mode (shutdown bit 1) the master clocks a byte out. The block leaves the line released, so the master reads all ones, and the STOP then commits power-down. A single-cycle strobe marks each commit.

Top module: `dac2w_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal {5'b01100, addr_sel} (0x30 to 0x33), for either value of the eighth bit. It does so by asserting sda_pull_o so that the data line reads low in the high phase of the 9th clock.
- R2: A non-matching address leaves sda_pull_o low for the rest of the transfer. This includes the general call address 0x00 and the 10-bit prefix 7'b11110xx.
- R3: With the eighth bit at 0, the following byte is taken MSB first and acknowledged on its 9th clock. At the next STOP, code_o takes that byte and pdown_o becomes 0.
- R4: With the eighth bit at 1, sda_pull_o stays low during the 8 data clocks and their 9th clock, so the master reads 0xFF. At the next STOP, pdown_o becomes 1 and code_o keeps its value.
- R5: A STOP that comes before a complete second byte leaves code_o and pdown_o unchanged and gives no strobe.
- R6: A repeated START, sent at any point, restarts address reception and discards any received byte. A later complete frame still commits.
- R7: Bytes after the data byte are not acknowledged and do not alter the values committed at STOP.
- R8: sda_pull_o changes only after the synchronised clock line has been seen low. It is therefore constant through each clock high phase.
- R9: code_o and pdown_o change only in the cycle where commit_o is high, and commit_o never stays high for two cycles in a row.
- R10: While rst_n is low, code_o is 0x00 and pdown_o, commit_o and sda_pull_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 2 | Selects the low two address bits |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| code_o | output | 8 | Committed converter code |
| pdown_o | output | 1 | Committed shutdown flag |
| commit_o | output | 1 | One-cycle strobe when the outputs update |

## Verification
A vector table walks every select value with matching addresses, neighbouring wrong addresses, the general call and a 10-bit prefix. This separates the address match from the mode bit. Each frame is sent as a normal write, as a shutdown read or as an address-only transfer, so a commit on STOP can be told apart from a commit on the byte or on the acknowledge. Directed frames insert repeated STARTs before and after the data byte and add trailing bytes, which shows whether the frame state is really reset. Every bus clock high phase is sampled twice to catch an acknowledge that moves while the clock is high.

// File: rtl/dac2w_pkg.sv
package dac2w_pkg;
    localparam int BYTE_BITS = 8;
    localparam int ADDR_W    = 7;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_DATA,
        ST_DACK,
        ST_SKIP
    } st_e;

    typedef struct packed {
        st_e                  st;
        logic [CNT_W-1:0]     cnt;
        logic [BYTE_BITS-1:0] sh;
        logic                 pd_req;
        logic                 full;
        logic                 pull;
        logic [BYTE_BITS-1:0] code;
        logic                 pdown;
        logic                 commit;
    } frame_t;
endpackage

// File: rtl/dac2w_sync.sv
module dac2w_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d_i[g]};
        end
        assign q_o[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/dac2w_cond.sv
module dac2w_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign rise_o  =  scl_s & ~scl_p;
    assign fall_o  = ~scl_s &  scl_p;
    assign start_o =  scl_s &  scl_p &  sda_p & ~sda_s;
    assign stop_o  =  scl_s &  scl_p & ~sda_p &  sda_s;
endmodule

// File: rtl/dac2w_frame.sv
module dac2w_frame
    import dac2w_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ADDR_BASE = 7'h30,
    parameter int                SEL_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     sel_i,
    input  logic                 sda_s,
    input  logic                 rise_i,
    input  logic                 fall_i,
    input  logic                 start_i,
    input  logic                 stop_i,
    output logic                 pull_o,
    output logic [BYTE_BITS-1:0] code_o,
    output logic                 pdown_o,
    output logic                 commit_o,
    output st_e                  st_o,
    output logic                 pd_req_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_BITS);

    frame_t q, d;
    logic [ADDR_W-1:0] my_addr;

    assign my_addr = {ADDR_BASE[ADDR_W-1:SEL_W], sel_i};

    always_comb begin
        d        = q;
        d.commit = 1'b0;
        if (start_i) begin
            d.st   = ST_ADDR;
            d.cnt  = '0;
            d.full = 1'b0;
            d.pull = 1'b0;
        end else if (stop_i) begin
            if (q.full) begin
                d.commit = 1'b1;
                d.pdown  = q.pd_req;
                if (!q.pd_req) d.code = q.sh;
            end
            d.st   = ST_IDLE;
            d.full = 1'b0;
            d.pull = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (rise_i) begin
                        d.sh  = {q.sh[BYTE_BITS-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (fall_i && q.cnt == LAST) begin
                        if (q.sh[BYTE_BITS-1:1] == my_addr) begin
                            d.pull   = 1'b1;
                            d.pd_req = q.sh[0];
                            d.st     = ST_AACK;
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                end
                ST_AACK: begin
                    if (fall_i) begin
                        d.pull = 1'b0;
                        d.cnt  = '0;
                        d.st   = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (rise_i) begin
                        d.sh  = {q.sh[BYTE_BITS-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (fall_i && q.cnt == LAST) begin
                        d.full = 1'b1;
                        d.pull = ~q.pd_req;
                        d.st   = ST_DACK;
                    end
                end
                ST_DACK: begin
                    if (fall_i) begin
                        d.pull = 1'b0;
                        d.st   = ST_SKIP;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.cnt    <= '0;
            q.sh     <= '0;
            q.pd_req <= 1'b0;
            q.full   <= 1'b0;
            q.pull   <= 1'b0;
            q.code   <= '0;
            q.pdown  <= 1'b0;
            q.commit <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pull_o   = q.pull;
    assign code_o   = q.code;
    assign pdown_o  = q.pdown;
    assign commit_o = q.commit;
    assign st_o     = q.st;
    assign pd_req_o = q.pd_req;
endmodule

// File: rtl/dac2w_slave.sv
module dac2w_slave #(
    parameter logic [6:0] ADDR_BASE   = 7'h30,
    parameter int         SEL_W       = 2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [SEL_W-1:0] addr_sel,
    output logic             sda_pull_o,
    output logic [7:0]       code_o,
    output logic             pdown_o,
    output logic             commit_o
);
    logic scl_s, sda_s;
    logic rise, fall, start, stop;
    dac2w_pkg::st_e st;
    logic pd_req;

    dac2w_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   ({scl_s, sda_s})
    );

    dac2w_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .rise_o  (rise),
        .fall_o  (fall),
        .start_o (start),
        .stop_o  (stop)
    );

    dac2w_frame #(.ADDR_BASE(ADDR_BASE), .SEL_W(SEL_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (addr_sel),
        .sda_s    (sda_s),
        .rise_i   (rise),
        .fall_i   (fall),
        .start_i  (start),
        .stop_i   (stop),
        .pull_o   (sda_pull_o),
        .code_o   (code_o),
        .pdown_o  (pdown_o),
        .commit_o (commit_o),
        .st_o     (st),
        .pd_req_o (pd_req)
    );
endmodule

// File: rtl/dac2w_slave_chk.sv
module dac2w_slave_chk (
    input logic           clk,
    input logic           rst_n,
    input logic           scl_s,
    input logic           sda_pull_o,
    input logic [7:0]     code_o,
    input logic           pdown_o,
    input logic           commit_o,
    input dac2w_pkg::st_e st,
    input logic           pd_req
);
    import dac2w_pkg::*;

    p_pull_low_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !$past(scl_s));

    p_code_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> commit_o);

    p_pdown_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pdown_o) |-> commit_o);

    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

    p_read_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && pd_req) |-> !sda_pull_o);

    p_skip_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |-> !sda_pull_o);

    p_reset_vals_r10: assert property (@(posedge clk)
        !rst_n |=> (code_o == 8'h00 && !pdown_o && !sda_pull_o && !commit_o));
endmodule

bind dac2w_slave dac2w_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .sda_pull_o (sda_pull_o),
    .code_o     (code_o),
    .pdown_o    (pdown_o),
    .commit_o   (commit_o),
    .st         (st),
    .pd_req     (pd_req)
);

// File: tb/dac2w_slave_test.sv
module dac2w_slave_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] sel = 2'd0;
    logic       sda_pull_o, pdown_o, commit_o;
    logic [7:0] code_o;
    wire        sda_line = sda_m & ~sda_pull_o;

    int n_tests = 0, n_fail = 0, n_commit = 0, n_unstable = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dac2w_slave uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .addr_sel   (sel),
        .sda_pull_o (sda_pull_o),
        .code_o     (code_o),
        .pdown_o    (pdown_o),
        .commit_o   (commit_o)
    );

    always @(negedge clk) if (rst_n && commit_o) n_commit++;

    // {sel, addr7, mode bit, data, full frame, expected address ack}
    localparam logic [19:0] VEC [11] = '{
        {2'd0, 7'h30, 1'b0, 8'hA5, 1'b1, 1'b1},
        {2'd1, 7'h31, 1'b0, 8'h3C, 1'b1, 1'b1},
        {2'd2, 7'h33, 1'b0, 8'h77, 1'b1, 1'b0},
        {2'd3, 7'h33, 1'b0, 8'hFF, 1'b1, 1'b1},
        {2'd2, 7'h32, 1'b1, 8'h00, 1'b1, 1'b1},
        {2'd2, 7'h32, 1'b0, 8'h01, 1'b1, 1'b1},
        {2'd0, 7'h32, 1'b0, 8'h55, 1'b1, 1'b0},
        {2'd1, 7'h31, 1'b1, 8'h00, 1'b0, 1'b1},
        {2'd0, 7'h00, 1'b0, 8'h12, 1'b1, 1'b0},
        {2'd1, 7'h79, 1'b0, 8'h34, 1'b1, 1'b0},
        {2'd0, 7'h30, 1'b0, 8'h80, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic late);
        logic early;
        wait_n(3); sda_m = b; wait_n(3);
        scl_m = 1'b1;
        wait_n(1); early = sda_line;
        wait_n(5); late = sda_line;
        if (early !== late) n_unstable++;
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic [7:0] seen);
        logic l;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(b[i], l);
            seen[i] = l;
        end
        clk_bit(1'b1, l);
        ack = ~l;
    endtask

    task automatic do_start;
        wait_n(3); sda_m = 1'b1; wait_n(3);
        scl_m = 1'b1; wait_n(6);
        sda_m = 1'b0; wait_n(6);
        scl_m = 1'b0;
    endtask

    task automatic do_stop;
        wait_n(3); sda_m = 1'b0; wait_n(3);
        scl_m = 1'b1; wait_n(6);
        sda_m = 1'b1; wait_n(8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] m_code, seen, db;
        logic       m_pd, ack, dack, match, full, pdb;
        int         m_commit;
        string      tag;
        m_code = 8'h00; m_pd = 1'b0; m_commit = 0;

        wait_n(4);
        // R10: reset values
        check("R10 code", code_o, 8'h00);
        check("R10 pdown", pdown_o, 1'b0);
        check("R10 pull", sda_pull_o, 1'b0);
        check("R10 strobe", commit_o, 1'b0);
        rst_n = 1'b1;
        wait_n(4);

        for (int i = 0; i < 11; i++) begin
            sel   = VEC[i][19:18];
            pdb   = VEC[i][10];
            full  = VEC[i][1];
            match = VEC[i][0];
            tag   = !full ? "R5" : (pdb ? "R4" : "R3");
            do_start;
            send_byte({VEC[i][17:11], pdb}, ack, seen);
            check(match ? "R1 addr ack" : "R2 addr nack", ack, match);
            if (full) begin
                db = pdb ? 8'hFF : VEC[i][9:2];
                send_byte(db, dack, seen);
                if (match && pdb) begin
                    check("R4 read ones", seen, 8'hFF);
                    check("R4 no ack", dack, 1'b0);
                end else if (match) begin
                    check("R3 data ack", dack, 1'b1);
                end else begin
                    check("R2 data nack", dack, 1'b0);
                end
            end
            do_stop;
            if (match && full) begin
                m_commit++;
                m_pd = pdb;
                if (!pdb) m_code = VEC[i][9:2];
            end
            check({tag, " code"}, code_o, m_code);
            check({tag, " pdown"}, pdown_o, m_pd);
            check("R9 strobes", n_commit, m_commit);
        end

        // R6: repeated START right after the address acknowledge, then a full write
        sel = 2'd0;
        do_start;
        send_byte({7'h30, 1'b1}, ack, seen);
        check("R1 addr ack pd", ack, 1'b1);
        do_start;
        check("R5 code after rstart", code_o, m_code);
        check("R5 pdown after rstart", pdown_o, m_pd);
        send_byte({7'h30, 1'b0}, ack, seen);
        check("R6 readdress ack", ack, 1'b1);
        send_byte(8'h44, dack, seen);
        do_stop;
        m_code = 8'h44; m_pd = 1'b0; m_commit++;
        check("R6 code", code_o, m_code);
        check("R6 strobes", n_commit, m_commit);

        // R6: repeated START after a complete byte discards it
        do_start;
        send_byte({7'h30, 1'b0}, ack, seen);
        send_byte(8'h99, dack, seen);
        do_start;
        do_stop;
        check("R6 discard code", code_o, m_code);
        check("R6 discard strobes", n_commit, m_commit);

        // R7: trailing bytes ignored
        do_start;
        send_byte({7'h30, 1'b0}, ack, seen);
        send_byte(8'h11, dack, seen);
        check("R3 ack before extra", dack, 1'b1);
        send_byte(8'h22, dack, seen);
        check("R7 extra nack", dack, 1'b0);
        send_byte(8'h33, dack, seen);
        check("R7 extra nack 2", dack, 1'b0);
        do_stop;
        m_code = 8'h11; m_commit++;
        check("R7 code", code_o, m_code);
        check("R7 strobes", n_commit, m_commit);

        // R8: pull-down constant over every high phase
        check("R8 unstable phases", n_unstable, 0);

        // R10: reset again clears committed state
        rst_n = 1'b0;
        wait_n(2);
        check("R10 code again", code_o, 8'h00);
        check("R10 pdown again", pdown_o, 1'b0);
        rst_n = 1'b1;
        wait_n(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule